// File: doc/BRIEF.md
# Compact-Encoded Barrel Shifter

This block is the execution unit for a single shift opcode of a small 16-bit processor. One opcode covers three kinds of shift (logical right, arithmetic right and left) and two amount sources (an immediate carried in the instruction, or a register value). Which kind and which amount apply is packed densely into a 6-bit field: a sign bit plus a 5-bit low field. The block decodes that field and shifts the 16-bit operand through a logarithmic stage network in one combinational pass.

The surrounding pipeline supplies the source operand, the value of the second source register and the two instruction fields. It takes back the shifted result and a one-hot code naming the kind of shift performed. Register selection and writeback stay outside. Immediate left shifts by 8 to 15 have no encoding, and software splits them into two instructions.

Top module: `cshift_top`

## Requirements
- R1: With `sign_i`=0 and `fld_i[4]`=0, `result_o` is `operand_i` shifted right logically by `fld_i[3:0]`, and `kind_o` is 3'b001.
- R2: With `sign_i`=0 and `fld_i[4]`=1, `result_o` is `operand_i` shifted right arithmetically by `fld_i[3:0]`, and `kind_o` is 3'b010.
- R3: With `sign_i`=1 and `fld_i[4:3]`=2'b00, `result_o` is a logical right shift by the register amount, and `kind_o` is 3'b001.
- R4: With `sign_i`=1 and `fld_i[4:3]`=2'b01, `result_o` is a left shift by the register amount, and `kind_o` is 3'b100.
- R5: With `sign_i`=1 and `fld_i[4:3]`=2'b10, `result_o` is an arithmetic right shift by the register amount, and `kind_o` is 3'b010.
- R6: With `sign_i`=1 and `fld_i[4:3]`=2'b11, `result_o` is a left shift by `fld_i[2:0]` (0 to 7), `kind_o` is 3'b100, and `rs2_i` has no effect.
- R7: A register amount is `rs2_i[3:0]`. Bits 15:4 of `rs2_i` have no effect, and in the immediate forms all of `rs2_i` has no effect.
- R8: An arithmetic right shift fills vacated bits with `operand_i[15]`. Logical right and left shifts fill with zeros.
- R9: A shift amount of 0 returns `operand_i` unchanged, whatever the kind.
- R10: `kind_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Instruction sign bit; selects the immediate-4 forms (0) or the other forms (1) |
| fld_i | input | 5 | Low instruction field carrying the sub-operation and the immediate amount |
| operand_i | input | 16 | Value to be shifted |
| rs2_i | input | 16 | Second source register value; its low 4 bits give the register amount |
| result_o | output | 16 | Shifted value |
| kind_o | output | 3 | One-hot shift kind: bit 0 logical right, bit 1 arithmetic right, bit 2 left |

## Verification
The block holds no state, so a wrong decode or a broken stage shows on `result_o` or `kind_o` for the same input pattern that provokes it. A misrouted amount bit shows only for amounts that use that bit, so every amount is swept for every form. A wrong fill shows only on operands whose top bit is set. An amount source mixed up between the register and the immediate shows only when the two disagree, so the vectors keep `rs2_i` and the field different.

// File: rtl/cshift_pkg.sv
package cshift_pkg;
  localparam int DATA_W = 16;
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int FLD_W  = 5;
  localparam int IMM3_W = 3;

  typedef enum logic [2:0] {
    KIND_SRL = 3'b001,
    KIND_SRA = 3'b010,
    KIND_SLL = 3'b100
  } shift_kind_e;
endpackage

// File: rtl/cshift_decode.sv
module cshift_decode
  import cshift_pkg::*;
(
  input  logic              sign_i,
  input  logic [FLD_W-1:0]  fld_i,
  input  logic [DATA_W-1:0] rs2_i,
  output shift_kind_e       kind_o,
  output logic [AMT_W-1:0]  amt_o
);
  logic [AMT_W-1:0] reg_amt;
  logic [AMT_W-1:0] imm_amt;
  logic [AMT_W-1:0] imm3_amt;

  // Register amount keeps only the bits that can address a data position.
  assign reg_amt  = rs2_i[AMT_W-1:0];
  assign imm_amt  = fld_i[AMT_W-1:0];
  assign imm3_amt = AMT_W'(fld_i[IMM3_W-1:0]);

  always_comb begin
    kind_o = KIND_SRL;
    amt_o  = imm_amt;
    if (!sign_i) begin
      kind_o = fld_i[4] ? KIND_SRA : KIND_SRL;
      amt_o  = imm_amt;
    end else begin
      unique case (fld_i[4:3])
        2'b00:   begin kind_o = KIND_SRL; amt_o = reg_amt;  end
        2'b01:   begin kind_o = KIND_SLL; amt_o = reg_amt;  end
        2'b10:   begin kind_o = KIND_SRA; amt_o = reg_amt;  end
        default: begin kind_o = KIND_SLL; amt_o = imm3_amt; end
      endcase
    end
  end
endmodule

// File: rtl/cshift_core.sv
module cshift_core
  import cshift_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] data_o
);
  logic              go_left;
  logic              fill;
  logic [DATA_W-1:0] data_rev;
  logic [DATA_W-1:0] net_out_rev;
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign go_left = (kind_i == KIND_SLL);
  assign fill    = (kind_i == KIND_SRA) & data_i[DATA_W-1];

  // Left shifts reuse the right-shift network on the bit-reversed value.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign data_rev[b]    = data_i[DATA_W-1-b];
    assign net_out_rev[b] = stage[AMT_W][DATA_W-1-b];
  end

  assign stage[0] = go_left ? data_rev : data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{SH{fill}}, stage[s][DATA_W-1:SH]}
                                 : stage[s];
  end

  assign data_o = go_left ? net_out_rev : stage[AMT_W];
endmodule

// File: rtl/cshift_top.sv
module cshift_top
  import cshift_pkg::*;
(
  input  logic              sign_i,
  input  logic [FLD_W-1:0]  fld_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] rs2_i,
  output logic [DATA_W-1:0] result_o,
  output logic [2:0]        kind_o
);
  shift_kind_e      kind;
  logic [AMT_W-1:0] amt;

  cshift_decode u_decode (
    .sign_i (sign_i),
    .fld_i  (fld_i),
    .rs2_i  (rs2_i),
    .kind_o (kind),
    .amt_o  (amt)
  );

  cshift_core u_core (
    .data_i (operand_i),
    .amt_i  (amt),
    .kind_i (kind),
    .data_o (result_o)
  );

  assign kind_o = kind;
endmodule

// File: rtl/cshift_chk.sv
module cshift_chk
  import cshift_pkg::*;
(
  input logic              sign_i,
  input logic [FLD_W-1:0]  fld_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] rs2_i,
  input logic [DATA_W-1:0] result_o,
  input logic [2:0]        kind_o
);
  always_comb begin
    assert_kind_onehot_R10: assert ($onehot(kind_o))
      else $error("kind not one-hot");

    if (!sign_i && fld_i[4])
      assert_imm_arith_kind_R2: assert (kind_o == 3'b010)
        else $error("immediate arithmetic form decoded wrongly");

    if (sign_i && fld_i[4:3] == 2'b11)
      assert_imm3_left_kind_R6: assert (kind_o == 3'b100)
        else $error("imm3 form not decoded as left shift");

    if (sign_i && fld_i[4:3] == 2'b11 && fld_i[2:0] != 3'b000)
      assert_imm3_low_zero_R6: assert (result_o[0] == 1'b0)
        else $error("left shift left a low bit set");

    if (kind_o == 3'b010)
      assert_arith_keeps_msb_R8: assert (result_o[DATA_W-1] == operand_i[DATA_W-1])
        else $error("arithmetic shift lost sign");

    if (kind_o == 3'b001)
      assert_logical_not_grow_R1: assert (result_o <= operand_i)
        else $error("logical right shift grew value");

    if (!sign_i && fld_i[3:0] == 4'd0)
      assert_zero_imm_pass_R9: assert (result_o == operand_i)
        else $error("zero immediate altered operand");

    if (sign_i && fld_i[4:3] != 2'b11 && rs2_i[3:0] == 4'd0)
      assert_zero_reg_pass_R7: assert (result_o == operand_i)
        else $error("zero register amount altered operand");
  end
endmodule

bind cshift_top cshift_chk chk_i (
  .sign_i    (sign_i),
  .fld_i     (fld_i),
  .operand_i (operand_i),
  .rs2_i     (rs2_i),
  .result_o  (result_o),
  .kind_o    (kind_o)
);

// File: tb/cshift_top_tb_top.sv
module cshift_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk;
  logic        sign;
  logic [4:0]  fld;
  logic [15:0] operand;
  logic [15:0] rs2;
  logic [15:0] result;
  logic [2:0]  kind;

  int checks = 0;
  int fails  = 0;

  cshift_top dut_i (
    .sign_i    (sign),
    .fld_i     (fld),
    .operand_i (operand),
    .rs2_i     (rs2),
    .result_o  (result),
    .kind_o    (kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {sign, fld, operand, rs2, expected result, expected kind}
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 5'b00100, 16'h8421, 16'h0007, 16'h0842, 3'b001},  // R1 srl imm 4
    {1'b0, 5'b10100, 16'h8421, 16'h0007, 16'hF842, 3'b010},  // R2 sra imm 4
    {1'b1, 5'b00101, 16'h8421, 16'h0013, 16'h1084, 3'b001},  // R3 srl rs2 (R7 upper ignored)
    {1'b1, 5'b01000, 16'h8421, 16'h0005, 16'h8420, 3'b100},  // R4 sll rs2 5
    {1'b1, 5'b10000, 16'h8421, 16'hFFF8, 16'hFF84, 3'b010},  // R5 sra rs2 8
    {1'b1, 5'b11111, 16'h8421, 16'h0002, 16'h1080, 3'b100},  // R6 sll imm3 7
    {1'b0, 5'b00000, 16'hBEEF, 16'h0009, 16'hBEEF, 3'b001},  // R9 zero imm
    {1'b0, 5'b11111, 16'h8000, 16'h0000, 16'hFFFF, 3'b010},  // R8 sign fill
    {1'b0, 5'b11111, 16'h7FFF, 16'h0000, 16'h0000, 3'b010},  // R8 positive
    {1'b1, 5'b01010, 16'h0003, 16'h000F, 16'h8000, 3'b100},  // R4 max amount
    {1'b1, 5'b11000, 16'h1234, 16'hFFFF, 16'h1234, 3'b100},  // R6 imm3 zero
    {1'b1, 5'b00110, 16'hCAFE, 16'h0010, 16'hCAFE, 3'b001},  // R7 bit4 ignored
    {1'b0, 5'b00001, 16'h0002, 16'h000F, 16'h0001, 3'b001}   // R7 imm ignores rs2
  };

  task automatic apply(input logic s, input logic [4:0] f,
                       input logic [15:0] op, input logic [15:0] r2);
    sign = s; fld = f; operand = op; rs2 = r2;
    #(CLK_PERIOD/2);
  endtask

  task automatic check(input string req, input logic [15:0] exp_res,
                       input logic [2:0] exp_kind);
    checks++;
    if (result !== exp_res || kind !== exp_kind) begin
      fails++;
      $display("FAIL %s: result=%h kind=%b expected result=%h kind=%b",
               req, result, kind, exp_res, exp_kind);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] op;
    sign = 1'b0; fld = '0; operand = '0; rs2 = '0;
    #(CLK_PERIOD);
    // Idle inputs: zero shift, R9 and R10
    check("R9 idle", 16'h0000, 3'b001);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][56], VEC[i][55:51], VEC[i][50:35], VEC[i][34:19]);
      check($sformatf("R1-R9 table row %0d", i), VEC[i][18:3], VEC[i][2:0]);
    end

    op = 16'h9AC3;
    for (int a = 0; a < 16; a++) begin
      apply(1'b0, {1'b0, 4'(a)}, op, 16'h5555);
      check($sformatf("R1 amt %0d", a), op >> a, 3'b001);
      apply(1'b0, {1'b1, 4'(a)}, op, 16'h5555);
      check($sformatf("R2 R8 amt %0d", a), 16'($signed(op) >>> a), 3'b010);
      apply(1'b1, 5'b00000, op, {12'hABC, 4'(a)});
      check($sformatf("R3 R7 amt %0d", a), op >> a, 3'b001);
      apply(1'b1, 5'b01101, op, {12'h3F0, 4'(a)});
      check($sformatf("R4 R7 amt %0d", a), op << a, 3'b100);
      apply(1'b1, 5'b10010, op, {12'hFFF, 4'(a)});
      check($sformatf("R5 R8 amt %0d", a), 16'($signed(op) >>> a), 3'b010);
    end
    for (int a = 0; a < 8; a++) begin
      apply(1'b1, {2'b11, 3'(a)}, op, 16'h000F);
      check($sformatf("R6 amt %0d", a), op << a, 3'b100);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule